// File: doc/BRIEF.md
# Segmented thermometer decoder for a current-steering converter

This block turns a binary sample word into the switch controls of a segmented current-steering converter. The word is cut into three fields. The top field is thermometer-decoded into a bank of equal high-weight cells. The middle field is thermometer-decoded into a bank of equal mid-weight cells. The bottom field drives binary-weighted unit cells directly. Each cell gets a true control, which steers its current to the output node, and a complement control, which steers it to the opposite node.

The word is captured in an input register. On the next edge all control registers load together, so the three segments never switch out of step. The decode has one register stage at its output. The default split is 5-4-1 on a 10-bit word: 31 high cells of weight 32, 15 mid cells of weight 2 and one unit cell.

Top module: `segdac_decoder`

## Requirements
- R1: With the default split, code bits [9:5] set the high segment, bits [4:1] set the mid segment and bit [0] sets the unit cell.
- R2: The high segment has 2^MSB_BITS-1 controls (31 by default) and the mid segment has 2^MID_BITS-1 controls (15 by default). The unit segment has LSB_BITS binary controls.
- R3: For a thermometer field value k, controls [k-1:0] of that segment are 1 and all higher controls are 0.
- R4: `lsb_on_o` equals the low field of the code, bit for bit, with no thermometer coding.
- R5: Out of reset, every `*_off_o` bit is the inverse of the matching `*_on_o` bit.
- R6: The weighted count of active true controls equals the input code for every code from 0 to 1023. The weights are 32 per high cell, 2 per mid cell and 1 for the unit cell.
- R7: A code present at rising edge n appears on all outputs right after rising edge n+1. Until then the outputs hold the previous code, and all segments change on the same edge.
- R8: Driving `rst_ni` low at once forces every true control to 0 and every complement control to 1, which is code 0. This does not wait for a clock edge.
- R9: Code 1023 puts every cell on the true side, and code 0 puts every cell on the complement side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | MSB_BITS+MID_BITS+LSB_BITS | Binary sample word |
| msb_on_o | output | 2^MSB_BITS-1 | High-segment true controls |
| msb_off_o | output | 2^MSB_BITS-1 | High-segment complement controls |
| mid_on_o | output | 2^MID_BITS-1 | Mid-segment true controls |
| mid_off_o | output | 2^MID_BITS-1 | Mid-segment complement controls |
| lsb_on_o | output | LSB_BITS | Unit-cell true controls |
| lsb_off_o | output | LSB_BITS | Unit-cell complement controls |

## Verification
The bench builds the block with its default 5-4-1 split on a 10-bit word. At that size all 1024 codes can be streamed back to back, one per cycle. Every carry from the unit bit into the mid bank, and from the mid bank into the high bank, is therefore checked against both the exact thermometer patterns and the weighted sum. The same size lets directed cases pin down the two-edge latency, the extreme codes and an asynchronous reset taken mid-stream.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  function automatic int unsigned seg_cells(int unsigned width);
    return (1 << width) - 1;
  endfunction
endpackage

// File: rtl/segdac_thermo_dec.sv
module segdac_thermo_dec #(
  parameter int unsigned FIELD_W = 4,
  localparam int unsigned CELLS  = (1 << FIELD_W) - 1
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CELLS-1:0]   therm_o
);
  // Cell i is on when the field exceeds i: k lowest cells on.
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam logic [FIELD_W-1:0] IDX = FIELD_W'(i);
    assign therm_o[i] = (field_i > IDX);
  end
endmodule

// File: rtl/segdac_ctrl_reg.sv
module segdac_ctrl_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] on_o,
  output logic [W-1:0] off_o
);
  // True and complement are separate flops so neither waits on an inverter.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= '0;
      off_o <= '1;
    end else begin
      on_o  <= d_i;
      off_o <= ~d_i;
    end
  end

  p_complement_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o == ~on_o)
    else $error("R5: complement mismatch");
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
  import segdac_pkg::*;
#(
  parameter int unsigned MSB_BITS = 5,
  parameter int unsigned MID_BITS = 4,
  parameter int unsigned LSB_BITS = 1,
  localparam int unsigned CODE_W    = MSB_BITS + MID_BITS + LSB_BITS,
  localparam int unsigned MSB_CELLS = seg_cells(MSB_BITS),
  localparam int unsigned MID_CELLS = seg_cells(MID_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CODE_W-1:0]    code_i,
  output logic [MSB_CELLS-1:0] msb_on_o,
  output logic [MSB_CELLS-1:0] msb_off_o,
  output logic [MID_CELLS-1:0] mid_on_o,
  output logic [MID_CELLS-1:0] mid_off_o,
  output logic [LSB_BITS-1:0]  lsb_on_o,
  output logic [LSB_BITS-1:0]  lsb_off_o
);
  localparam int unsigned MID_LO = LSB_BITS;
  localparam int unsigned MSB_LO = LSB_BITS + MID_BITS;
  localparam int unsigned SUM_W  = CODE_W + 1;

  logic [CODE_W-1:0]    code_q;
  logic [MSB_CELLS-1:0] msb_therm;
  logic [MID_CELLS-1:0] mid_therm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_i;
  end

  segdac_thermo_dec #(.FIELD_W(MSB_BITS)) u_msb_dec (
    .field_i (code_q[CODE_W-1:MSB_LO]),
    .therm_o (msb_therm)
  );

  segdac_thermo_dec #(.FIELD_W(MID_BITS)) u_mid_dec (
    .field_i (code_q[MSB_LO-1:MID_LO]),
    .therm_o (mid_therm)
  );

  segdac_ctrl_reg #(.W(MSB_CELLS)) u_msb_reg (
    .clk_i, .rst_ni, .d_i(msb_therm), .on_o(msb_on_o), .off_o(msb_off_o)
  );

  segdac_ctrl_reg #(.W(MID_CELLS)) u_mid_reg (
    .clk_i, .rst_ni, .d_i(mid_therm), .on_o(mid_on_o), .off_o(mid_off_o)
  );

  segdac_ctrl_reg #(.W(LSB_BITS)) u_lsb_reg (
    .clk_i, .rst_ni, .d_i(code_q[LSB_BITS-1:0]), .on_o(lsb_on_o), .off_o(lsb_off_o)
  );

  // Checker support: cycles since reset release, saturating at pipeline depth.
  logic [1:0]       warm_q;
  logic [SUM_W-1:0] cell_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  always_comb begin
    cell_sum = (SUM_W'($countones(msb_on_o)) << MSB_LO)
             + (SUM_W'($countones(mid_on_o)) << MID_LO)
             + SUM_W'(lsb_on_o);
  end

  p_weight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (cell_sum == SUM_W'($past(code_i, 2))))
    else $error("R6: weighted sum mismatch");

  p_msb_thermo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_on_o & (msb_on_o + MSB_CELLS'(1))) == '0)
    else $error("R3: high segment not thermometer");

  p_mid_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> ($countones(mid_on_o) == int'($past(code_i[MSB_LO-1:MID_LO], 2))))
    else $error("R3: mid segment count");

  p_lsb_direct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (lsb_on_o == $past(code_i[LSB_BITS-1:0], 2)))
    else $error("R4: unit cell mismatch");

  p_reset_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd0) |-> (msb_on_o == '0 && mid_on_o == '0 && lsb_on_o == '0))
    else $error("R8: not at code 0 after reset");
endmodule

// File: tb/segdac_decoder_test.sv
module segdac_decoder_test;
  localparam int MSB_CELLS = 31;
  localparam int MID_CELLS = 15;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [9:0]           code_i = '0;
  logic [MSB_CELLS-1:0] msb_on_o, msb_off_o;
  logic [MID_CELLS-1:0] mid_on_o, mid_off_o;
  logic [0:0]           lsb_on_o, lsb_off_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  segdac_decoder uut (
    .clk_i(clk), .rst_ni, .code_i,
    .msb_on_o, .msb_off_o, .mid_on_o, .mid_off_o, .lsb_on_o, .lsb_off_o
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] therm(input int k);
    return (64'd1 << k) - 64'd1;
  endfunction

  // Compare all ports against code c, built from the requirements.
  task automatic check_code(input string tag, input int c);
    int hi, mi, lo, sum;
    hi = (c >> 5) & 31;
    mi = (c >> 1) & 15;
    lo = c & 1;
    chk({tag, " R1/R3 msb"}, 64'(msb_on_o), therm(hi));
    chk({tag, " R1/R3 mid"}, 64'(mid_on_o), therm(mi));
    chk({tag, " R4 lsb"},    64'(lsb_on_o), 64'(lo));
    chk({tag, " R5 msb_off"}, 64'(msb_off_o), ~therm(hi) & therm(MSB_CELLS));
    chk({tag, " R5 mid_off"}, 64'(mid_off_o), ~therm(mi) & therm(MID_CELLS));
    chk({tag, " R5 lsb_off"}, 64'(lsb_off_o), 64'(1 - lo));
    sum = $countones(msb_on_o) * 32 + $countones(mid_on_o) * 2 + int'(lsb_on_o);
    chk({tag, " R6 sum"}, 64'(sum), 64'(c));
  endtask

  task automatic hold_and_check(input string tag, input int c);
    @(negedge clk) code_i = 10'(c);
    @(negedge clk);
    @(negedge clk);
    check_code(tag, c);
  endtask

  task automatic t_reset_state;
    code_i = 10'h3FF;
    repeat (3) @(negedge clk);
    check_code("R8 held reset", 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_code("R8 first cycle", 0);
  endtask

  task automatic t_counts;
    chk("R2 msb width", 64'($bits(msb_on_o)), 64'd31);
    chk("R2 mid width", 64'($bits(mid_on_o)), 64'd15);
    chk("R2 lsb width", 64'($bits(lsb_on_o)), 64'd1);
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 1026; c++) begin
      @(negedge clk);
      if (c >= 2) check_code("R6 sweep", c - 2);
      code_i = (c < 1024) ? 10'(c) : '0;
    end
  endtask

  task automatic t_fields;
    hold_and_check("R1 one high cell", 10'b00001_0000_0);
    hold_and_check("R1 mid full", 10'b00000_1111_0);
    hold_and_check("R3 field three", 10'b00011_0011_1);
    hold_and_check("R1 unit only", 10'b00000_0000_1);
  endtask

  task automatic t_extremes;
    hold_and_check("R9 all ones", 1023);
    chk("R9 all off zero", 64'({msb_off_o, mid_off_o, lsb_off_o}), 64'd0);
    hold_and_check("R9 all zeros", 0);
    chk("R9 all on zero", 64'({msb_on_o, mid_on_o, lsb_on_o}), 64'd0);
  endtask

  task automatic t_latency;
    hold_and_check("R7 base", 10'h2AA);
    @(negedge clk) code_i = 10'h155;
    @(negedge clk);
    check_code("R7 one edge old", 10'h2AA);
    @(negedge clk);
    check_code("R7 two edges new", 10'h155);
  endtask

  task automatic t_async_reset;
    hold_and_check("R8 pre", 1023);
    @(negedge clk);
    #3 rst_ni = 1'b0;
    #2 check_code("R8 async", 0);
    @(negedge clk) rst_ni = 1'b1;
    hold_and_check("R8 after release", 10'h21D);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_counts();
    t_sweep();
    t_fields();
    t_extremes();
    t_latency();
    t_async_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule